// File: doc/BRIEF.md
# Paged Effective Address Generator

This block works out the operand address of a memory-reference instruction for a machine with 12-bit words and a 4096-word address space. A caller presents a 7-bit offset, a page-select bit, an indirect bit and the current program counter, then pulses `start`. The direct address is either the offset placed in page zero, or the offset joined to the top five bits of the program counter.

When the indirect bit is set, the block reads the direct location from a synchronous single-port memory. The word it reads is the operand address. When that pointer location lies in the auto-increment window (0x008 to 0x00F), the block adds one to the pointer, writes the new value back to the same location and returns the new value. The `done` pulse marks the cycle in which `ea` is valid.

The controller uses five states:
- **IDLE**: waits for `start`. It goes to DONE for a direct reference and to PTR_RD for an indirect one.
- **PTR_RD**: issues the read and always goes to PTR_CAP.
- **PTR_CAP**: takes the memory word. It goes to PTR_WB for an auto-increment pointer and to DONE otherwise.
- **PTR_WB**: writes the incremented pointer back and goes to DONE.
- **DONE**: pulses `done` and returns to IDLE.

Top module: `eag_top`

## Requirements
- R1: After reset, `done`, `mem_re`, `mem_we` and `busy` are all low.
- R2: With `indirect`=0 and `page_sel`=0, `ea` = {5'b0, offset}. `done` is high exactly one cycle after the `start` cycle, and no memory access occurs. This holds even when that address lies in 0x008 to 0x00F.
- R3: With `indirect`=0 and `page_sel`=1, `ea` = {pc[11:7], offset}. The timing is the same as R2.
- R4: With `indirect`=1 and a direct address outside 0x008 to 0x00F:
  - one read is made from the direct address, with `mem_re` high in the cycle after `start`;
  - `ea` equals the word read;
  - `done` is high three cycles after `start`;
  - no write occurs.
- R5: With `indirect`=1 and a direct address inside 0x008 to 0x00F, whichever page select produced it:
  - the pointer is read;
  - the pointer plus one is written back to the same address, with `mem_we` high three cycles after `start`;
  - `ea` equals the incremented value;
  - `done` is high four cycles after `start`.
- R6: The auto-increment wraps modulo 4096, so a pointer of 0xFFF becomes 0x000.
- R7: Addresses just outside the window (0x007 and 0x010) used indirectly are never written.
- R8: A `start` pulse while `busy` is high is ignored: the running reference completes with its original result.
- R9: `done` lasts one cycle, and `mem_re` and `mem_we` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reference (sampled when idle) |
| offset | input | 7 | In-page word offset |
| page_sel | input | 1 | 1 = current page, 0 = page zero |
| indirect | input | 1 | 1 = direct location holds the operand address |
| pc | input | 12 | Current program counter |
| mem_rdata | input | 12 | Memory read data, valid the cycle after `mem_re` |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 12 | Memory write data |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| busy | output | 1 | Reference in progress |
| done | output | 1 | `ea` valid this cycle |
| ea | output | 12 | Effective address |

## Verification
The patterns are chosen so that each one separates a different pair of paths:
- **Direct, both page selects.** The program counter carries non-zero upper bits, so a mix-up between page zero and the current page changes the address.
- **Indirect, through either page.** Memory words unlike their own address are used, which exposes returning the pointer location instead of its contents.
- **Window edges.** Pointers at 0x008 and 0x00F are compared with 0x007 and 0x010, and window locations are also used directly, which isolates the range decode.
- **Wrap and repeats.** A pointer of 0xFFF shows the wrap. Two back-to-back uses of the same pointer show that the written value is the one read next time.
- **Start while busy.** A mid-operation `start` with different operands shows that the block ignores it.

// File: rtl/eag_pkg.sv
package eag_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PTR_RD  = 3'd1,
        ST_PTR_CAP = 3'd2,
        ST_PTR_WB  = 3'd3,
        ST_DONE    = 3'd4
    } eag_state_e;
endpackage

// File: rtl/eag_addr_form.sv
module eag_addr_form #(
    parameter int unsigned AW      = 12,
    parameter int unsigned OW      = 7,
    parameter int unsigned AUTO_LO = 8,
    parameter int unsigned AUTO_HI = 15
) (
    input  logic [AW-1:0] pc,
    input  logic [OW-1:0] offset,
    input  logic          page_sel,
    output logic [AW-1:0] dir_addr,
    output logic          is_auto
);
    localparam int unsigned PW = AW - OW;
    localparam logic [AW-1:0] LO_A = AW'(AUTO_LO);
    localparam logic [AW-1:0] HI_A = AW'(AUTO_HI);

    logic [PW-1:0] page_bits;

    // Page bits come from the program counter only when current page is selected
    generate
        if (PW > 0) begin : g_paged
            assign page_bits = page_sel ? pc[AW-1:OW] : '0;
        end
    endgenerate

    assign dir_addr = {page_bits, offset};

    always_comb begin
        is_auto = (dir_addr >= LO_A) && (dir_addr <= HI_A);
    end
endmodule

// File: rtl/eag_incr.sv
module eag_incr #(
    parameter int unsigned AW = 12
) (
    input  logic [AW-1:0] val_in,
    output logic [AW-1:0] val_out
);
    localparam logic [AW-1:0] ONE = AW'(1);

    // Natural wrap of an AW-bit sum gives modulo 2**AW
    assign val_out = val_in + ONE;
endmodule

// File: rtl/eag_fsm.sv
module eag_fsm
    import eag_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          indirect,
    input  logic [AW-1:0] dir_addr,
    input  logic          is_auto,
    input  logic [AW-1:0] mem_rdata,
    input  logic [AW-1:0] inc_val,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    output logic          mem_re,
    output logic          mem_we,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ea
);
    eag_state_e    state_q, state_d;
    logic [AW-1:0] ptr_q;
    logic          auto_q;
    logic [AW-1:0] ea_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = indirect ? ST_PTR_RD : ST_DONE;
            end
            ST_PTR_RD:  state_d = ST_PTR_CAP;
            ST_PTR_CAP: state_d = auto_q ? ST_PTR_WB : ST_DONE;
            ST_PTR_WB:  state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            auto_q <= 1'b0;
            ea_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ptr_q  <= dir_addr;
                        auto_q <= is_auto & indirect;
                        ea_q   <= dir_addr;
                    end
                end
                ST_PTR_CAP: ea_q <= auto_q ? inc_val : mem_rdata;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        done      = 1'b0;
        busy      = (state_q != ST_IDLE);
        unique case (state_q)
            ST_PTR_RD: begin
                mem_addr = ptr_q;
                mem_re   = 1'b1;
            end
            ST_PTR_WB: begin
                mem_addr  = ptr_q;
                mem_wdata = ea_q;
                mem_we    = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign ea = ea_q;

    // R9: read and write never overlap
    a_r9_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: a read is followed by a capture cycle with no access and no done
    a_r4_read_then_capture: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (!mem_re && !mem_we && !done));

    // R5: a write-back is followed by done
    a_r5_wb_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> done);

    // R5 / R6: write-back data is the word read plus one, modulo the word size
    a_r5_wb_is_incremented: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == AW'($past(mem_rdata) + 1'b1)));

    // R5: write-back targets the address that was just read
    a_r5_wb_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == $past(mem_addr, 2)));
endmodule

// File: rtl/eag_top.sv
module eag_top #(
    parameter int unsigned AW      = 12,
    parameter int unsigned OW      = 7,
    parameter int unsigned AUTO_LO = 8,
    parameter int unsigned AUTO_HI = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [OW-1:0] offset,
    input  logic          page_sel,
    input  logic          indirect,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    output logic          mem_re,
    output logic          mem_we,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ea
);
    logic [AW-1:0] dir_addr;
    logic          is_auto;
    logic [AW-1:0] inc_val;

    eag_addr_form #(
        .AW(AW), .OW(OW), .AUTO_LO(AUTO_LO), .AUTO_HI(AUTO_HI)
    ) u_form (
        .pc       (pc),
        .offset   (offset),
        .page_sel (page_sel),
        .dir_addr (dir_addr),
        .is_auto  (is_auto)
    );

    eag_incr #(.AW(AW)) u_incr (
        .val_in  (mem_rdata),
        .val_out (inc_val)
    );

    eag_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .indirect  (indirect),
        .dir_addr  (dir_addr),
        .is_auto   (is_auto),
        .mem_rdata (mem_rdata),
        .inc_val   (inc_val),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .busy      (busy),
        .done      (done),
        .ea        (ea)
    );

    // R1: nothing is active while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!done && !mem_re && !mem_we));
endmodule

// File: tb/tb_eag_top.sv
module tb_eag_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  offset = '0;
    logic        page_sel = 1'b0;
    logic        indirect = 1'b0;
    logic [11:0] pc = '0;
    logic [11:0] mem_rdata;
    logic [11:0] mem_addr, mem_wdata, ea;
    logic        mem_re, mem_we, busy, done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Bench-side memory and its preload port
    logic [11:0] mem_m [4096];
    logic        pre_en = 1'b0;
    logic [11:0] pre_a = '0;
    logic [11:0] pre_d = '0;

    always #10 clk = ~clk;

    eag_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .offset(offset),
        .page_sel(page_sel), .indirect(indirect), .pc(pc),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_we(mem_we), .busy(busy), .done(done), .ea(ea)
    );

    always @(posedge clk) begin
        if (pre_en) mem_m[pre_a] <= pre_d;
        else if (mem_we) mem_m[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem_m[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [11:0] d);
        @(negedge clk);
        pre_en = 1'b1; pre_a = a; pre_d = d;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    // Runs one reference and compares every cycle against a behavioural model
    task automatic run_op(input bit ps, input bit ind, input logic [6:0] ofs,
                          input logic [11:0] pcv, input string req, input bit glitch);
        logic [11:0] da, old, exp_ea;
        bit auto;
        int lat;
        da     = ps ? {pcv[11:7], ofs} : {5'b0, ofs};
        auto   = ind && (da >= 12'h008) && (da <= 12'h00F);
        old    = mem_m[da];
        exp_ea = !ind ? da : (auto ? 12'(old + 12'h001) : old);
        lat    = !ind ? 1 : (auto ? 4 : 3);
        @(negedge clk);
        page_sel = ps; indirect = ind; offset = ofs; pc = pcv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= lat; k++) begin
            chk(done == (k == lat), {req, " done timing"}, done, (k == lat));
            chk(mem_re == (ind && k == 1), {req, " read enable"}, mem_re, (ind && k == 1));
            chk(mem_we == (auto && k == 3), {req, " write enable"}, mem_we, (auto && k == 3));
            if (mem_re || mem_we) chk(mem_addr == da, {req, " mem address"}, mem_addr, da);
            if (auto && k == 3) chk(mem_wdata == exp_ea, {req, " write data"}, mem_wdata, exp_ea);
            if (k == lat) chk(ea == exp_ea, {req, " effective address"}, ea, exp_ea);
            if (glitch && k == 1) begin
                // R8: a new start with other operands while busy
                offset = ofs ^ 7'h55; page_sel = ~ps; indirect = ~ind; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk(!done && !busy, {req, " back to idle"}, {busy, done}, 0);
        if (auto) chk(mem_m[da] == 12'(old + 12'h001), {req, " pointer updated"}, mem_m[da], 12'(old + 12'h001));
        else      chk(mem_m[da] == old, {req, " location untouched"}, mem_m[da], old);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem_m[i] = 12'(i ^ 12'hA5A);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !mem_re && !mem_we && !busy, "R1 reset outputs", {done, mem_re, mem_we, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy, "R1 idle after reset", {done, busy}, 0);

        run_op(1'b0, 1'b0, 7'h55, 12'hABC, "R2 zero page direct", 1'b0);
        run_op(1'b0, 1'b0, 7'h09, 12'h3C0, "R2 window used directly", 1'b0);
        run_op(1'b1, 1'b0, 7'h13, 12'hABC, "R3 current page direct", 1'b0);
        run_op(1'b1, 1'b0, 7'h7F, 12'hF80, "R3 top page", 1'b0);

        poke(12'h020, 12'h7A1);
        run_op(1'b0, 1'b1, 7'h20, 12'h9FF, "R4 zero page indirect", 1'b0);
        poke(12'h310, 12'h0C4);
        run_op(1'b1, 1'b1, 7'h10, 12'h345, "R4 current page indirect", 1'b0);

        poke(12'h008, 12'h123);
        run_op(1'b0, 1'b1, 7'h08, 12'hFFF, "R5 low window edge", 1'b0);
        poke(12'h00F, 12'h400);
        run_op(1'b0, 1'b1, 7'h0F, 12'h000, "R5 high window edge", 1'b0);
        run_op(1'b0, 1'b1, 7'h0F, 12'h000, "R5 repeated pointer", 1'b0);
        poke(12'h00A, 12'h777);
        run_op(1'b1, 1'b1, 7'h0A, 12'h050, "R5 window through current page", 1'b0);

        poke(12'h00C, 12'hFFF);
        run_op(1'b0, 1'b1, 7'h0C, 12'h123, "R6 pointer wrap", 1'b0);

        poke(12'h007, 12'h5E5);
        run_op(1'b0, 1'b1, 7'h07, 12'h000, "R7 below window", 1'b0);
        poke(12'h010, 12'h6D6);
        run_op(1'b0, 1'b1, 7'h10, 12'h000, "R7 above window", 1'b0);

        poke(12'h00D, 12'h0AB);
        run_op(1'b0, 1'b1, 7'h0D, 12'h000, "R8 start while busy auto", 1'b1);
        run_op(1'b1, 1'b0, 7'h21, 12'h7C3, "R8 start while busy direct", 1'b1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule